// File: doc/BRIEF.md
# Keyed-Write Watchdog and Interval Timer

A peripheral that counts input clocks through a selectable power-of-two prescaler into an 8-bit up-counter. Software picks one of two behaviours when the counter wraps from 0xFF to 0x00. In watchdog mode the wrap sets a sticky watchdog flag and drives a reset request for a fixed number of cycles. In interval mode the wrap sets a sticky interval flag, and the interrupt output stays high until software clears that flag.

Stray stores must not disturb the timer, so every register write carries a key in its upper data byte. A write whose key does not match the addressed register is dropped entirely. Software keeps a watchdog from firing by reloading the counter with a keyed write. That reload also restarts the prescaler, so each reload grants a full tick period. The register bus is a plain single-cycle read/write port with no back-pressure. A write is taken on the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr` while `bus_rd` is high, and zero otherwise. The pins that request a reset, report the reset type and raise the interrupt are plain level outputs.

Top module: `keyed_wdt_top`

## Requirements
- R1: A write at offset 0x0 with upper byte 0x5A loads the lower byte into the counter. Any other upper byte leaves the counter unchanged. Reading offset 0x0 returns the counter value.
- R2: A write at offset 0x4 with upper byte 0xA5 updates the control/status register. Any other upper byte, and a counter-keyed write at this offset, changes nothing.
- R3: Control/status bits read back at offset 0x4 as follows: bit 7 enable, bit 6 mode (1 = watchdog, 0 = interval), bit 5 reset type, bit 4 watchdog flag, bit 3 interval flag, bits 2:0 clock select. After reset both registers read 0x00 and all outputs are low.
- R4: While enable is 1, the counter advances by one every 2^(5+select) clocks. Select 0 gives 32 clocks and select 1 gives 64 clocks. While enable is 0 the counter holds.
- R5: A keyed counter write clears the prescaler, so the next increment follows a full period after the write.
- R6: A wrap from 0xFF to 0x00 in watchdog mode sets the watchdog flag. It also holds `rst_req` high for 16 cycles, starting the cycle after the wrap. `rst_kind` shows the reset-type bit.
- R7: A wrap in interval mode sets the interval flag and never raises `rst_req`. `irq` is high exactly while the interval flag is set.
- R8: A keyed control write with 0 in a flag bit clears that flag. A 1 in a flag bit never sets the flag.
- R9: When a wrap and a keyed control write that clears the matching flag land on the same edge, the flag ends up set.
- R10: When a keyed counter write lands on the same edge as the increment that would wrap, the written value is loaded and no wrap happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_rd | input | 1 | Read enable for combinational read data |
| bus_addr | input | 3 | Byte offset: 0x0 counter, 0x4 control/status |
| bus_wdata | input | 16 | Write data: key in [15:8], value in [7:0] |
| bus_rdata | output | 8 | Read data of the addressed register |
| rst_req | output | 1 | Reset request pulse after a watchdog wrap |
| rst_kind | output | 1 | Current reset-type bit |
| irq | output | 1 | Interval interrupt, high while the interval flag is set |

## Verification
Two pairs of events can fall on one edge. A wrap can coincide with a software write that clears the matching flag, and a wrap increment can coincide with a reloading counter write. Each pair is provoked by loading 0xFF, which also clears the prescaler. The bench then counts exactly 31 edges and issues the competing write so that it is sampled on the 32nd edge, the one carrying the increment. The first pair passes if the flag reads back set and the reset pulse starts. The second passes if the counter reads the new value while both flags and `rst_req` stay low.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned KEY_W    = 8;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned OFF_CNT  = 0;
  localparam int unsigned OFF_CTL  = 4;
  localparam logic [KEY_W-1:0] KEY_CNT = 8'h5A;
  localparam logic [KEY_W-1:0] KEY_CTL = 8'hA5;

  // Packed so the field order equals the read-back bit order, MSB first.
  typedef struct packed {
    logic             run;      // bit 7
    logic             wd_mode;  // bit 6
    logic             rkind;    // bit 5
    logic             wd_flag;  // bit 4
    logic             it_flag;  // bit 3
    logic [SEL_W-1:0] sel;      // bits 2:0
  } ctl_t;
endpackage

// File: rtl/keyed_wdt_prescaler.sv
module keyed_wdt_prescaler #(
  parameter int unsigned BASE_LOG = 5,
  parameter int unsigned SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned NSEL = 1 << SEL_W;
  localparam int unsigned PW   = BASE_LOG + NSEL - 1;

  logic [PW-1:0] presc;
  logic [PW-1:0] term [NSEL];

  // One terminal count per select code: 2^(BASE_LOG+code) - 1.
  for (genvar g = 0; g < NSEL; g++) begin : g_term
    assign term[g] = PW'((64'd1 << (BASE_LOG + g)) - 64'd1);
  end

  assign tick = run && (presc == term[sel]);

  always_ff @(posedge clk) begin
    if (!rst_n)                  presc <= '0;
    else if (clr || !run || tick) presc <= '0;
    else                         presc <= presc + 1'b1;
  end

  // A cleared prescaler cannot reach any terminal count on the next cycle.
  assert_clear_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !tick);
endmodule

// File: rtl/keyed_wdt_counter.sv
module keyed_wdt_counter #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  // A reload on the same edge as the wrapping tick wins (R10).
  assign wrap = tick && !load && (cnt == {CW{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (tick) cnt <= cnt + 1'b1;
  end

  assert_load_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == $past(load_val));
  assert_halt_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt));
  assert_wrap_to_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == '0);
endmodule

// File: rtl/keyed_wdt_ctrl.sv
module keyed_wdt_ctrl
  import keyed_wdt_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] ctl_val,
  input  logic              wrap,
  output ctl_t              ctl,
  output logic              rst_req
);
  localparam int unsigned PCW = $clog2(RST_CYCLES + 1);

  ctl_t          wv;
  logic [PCW-1:0] pulse_left;
  logic          wd_hit, it_hit;

  assign wv     = ctl_t'(ctl_val);
  assign wd_hit = wrap && ctl.wd_mode;
  assign it_hit = wrap && !ctl.wd_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0;
    end else begin
      if (ctl_wr) begin
        ctl.run     <= wv.run;
        ctl.wd_mode <= wv.wd_mode;
        ctl.rkind   <= wv.rkind;
        ctl.sel     <= wv.sel;
      end
      // Flags: write may only clear; a hardware set on the same edge wins (R9).
      ctl.wd_flag <= (ctl.wd_flag & (!ctl_wr | wv.wd_flag)) | wd_hit;
      ctl.it_flag <= (ctl.it_flag & (!ctl_wr | wv.it_flag)) | it_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               pulse_left <= '0;
    else if (wd_hit)          pulse_left <= PCW'(RST_CYCLES);
    else if (pulse_left != 0) pulse_left <= pulse_left - 1'b1;
  end

  assign rst_req = (pulse_left != '0);

  assert_wd_flag_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl.wd_flag) |-> $past(wrap));
  assert_interval_no_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !ctl.wd_mode && !rst_req) |=> !rst_req);
  assert_flag_no_write_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap && !ctl.it_flag) |=> !ctl.it_flag);
  assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && ctl.wd_mode) |=> ctl.wd_flag);
endmodule

// File: rtl/keyed_wdt_top.sv
module keyed_wdt_top
  import keyed_wdt_pkg::*;
#(
  parameter int unsigned BASE_LOG   = 5,
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req,
  output logic              rst_kind,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(OFF_CNT);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFF_CTL);

  logic              cnt_wr, ctl_wr, tick, wrap;
  logic [DATA_W-1:0] cnt;
  ctl_t              ctl;

  assign cnt_wr = bus_wr && (bus_addr == A_CNT) && (bus_wdata[15:8] == KEY_CNT);
  assign ctl_wr = bus_wr && (bus_addr == A_CTL) && (bus_wdata[15:8] == KEY_CTL);

  keyed_wdt_prescaler #(.BASE_LOG(BASE_LOG), .SEL_W(SEL_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(ctl.run), .clr(cnt_wr),
    .sel(ctl.sel), .tick(tick));

  keyed_wdt_counter #(.CW(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctl.run), .load(cnt_wr),
    .load_val(bus_wdata[7:0]), .tick(tick), .cnt(cnt), .wrap(wrap));

  keyed_wdt_ctrl #(.RST_CYCLES(RST_CYCLES)) u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_val(bus_wdata[7:0]),
    .wrap(wrap), .ctl(ctl), .rst_req(rst_req));

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == A_CNT)      bus_rdata = cnt;
      else if (bus_addr == A_CTL) bus_rdata = DATA_W'(ctl);
    end
  end

  assign rst_kind = ctl.rkind;
  assign irq      = ctl.it_flag;

  assert_irq_follows_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(wrap));
  assert_badkey_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_wdata[15:8] != KEY_CTL && !wrap) |=> $stable(ctl));
endmodule

// File: tb/tb_keyed_wdt_top.sv
module tb_keyed_wdt_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        rst_req, rst_kind, irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  keyed_wdt_top dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rst_req(rst_req), .rst_kind(rst_kind), .irq(irq));

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; edges(3); rst_n = 1'b1; edges(1);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a; #0.5;
    d = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    rd(3'd0, d); check("R3 counter reset", d, 8'h00);
    rd(3'd4, d); check("R3 control reset", d, 8'h00);
    check("R3 outputs reset", {rst_req, rst_kind, irq}, 0);
  endtask

  task automatic t_keys();
    logic [7:0] d;
    do_reset();
    wr(3'd0, 16'h5A3C); rd(3'd0, d); check("R1 keyed load", d, 8'h3C);
    wr(3'd0, 16'h5B77); rd(3'd0, d); check("R1 bad key ignored", d, 8'h3C);
    wr(3'd0, 16'hA599); rd(3'd0, d); check("R1 control key at counter", d, 8'h3C);
    wr(3'd4, 16'hA527); rd(3'd4, d); check("R3 layout readback", d, 8'h27);
    check("R6 rst_kind follows bit5", rst_kind, 1);
    wr(3'd4, 16'hA4C0); rd(3'd4, d); check("R2 bad key ignored", d, 8'h27);
    wr(3'd4, 16'h5A00); rd(3'd4, d); check("R2 counter key at control", d, 8'h27);
    wr(3'd4, 16'hA518); rd(3'd4, d); check("R8 writing 1 sets no flag", d, 8'h00);
    check("R7 irq low", irq, 0);
  endtask

  task automatic t_rate();
    logic [7:0] d;
    do_reset();
    wr(3'd4, 16'hA580); wr(3'd0, 16'h5A10);
    edges(31); rd(3'd0, d); check("R4 sel0 before period", d, 8'h10);
    edges(1);  rd(3'd0, d); check("R4 sel0 at 32", d, 8'h11);
    wr(3'd4, 16'hA581); wr(3'd0, 16'h5A40);
    edges(63); rd(3'd0, d); check("R5 sel1 full period after ping", d, 8'h40);
    edges(1);  rd(3'd0, d); check("R4 sel1 at 64", d, 8'h41);
    wr(3'd4, 16'hA501);
    edges(200); rd(3'd0, d); check("R4 halted", d, 8'h41);
  endtask

  task automatic t_watchdog();
    logic [7:0] d;
    do_reset();
    wr(3'd4, 16'hA5E0); wr(3'd0, 16'h5AFF);
    edges(32);
    rd(3'd4, d); check("R6 watchdog flag", d, 8'hF0);
    rd(3'd0, d); check("R6 counter wrapped", d, 8'h00);
    check("R6 rst_req start", rst_req, 1);
    check("R6 rst_kind", rst_kind, 1);
    check("R7 no irq in watchdog mode", irq, 0);
    edges(15); check("R6 rst_req last cycle", rst_req, 1);
    edges(1);  check("R6 rst_req ends", rst_req, 0);
    wr(3'd4, 16'hA5F0); rd(3'd4, d); check("R8 writing 1 keeps flag", d, 8'hF0);
    wr(3'd4, 16'hA5E0); rd(3'd4, d); check("R8 clear flag", d, 8'hE0);
  endtask

  task automatic t_interval();
    logic [7:0] d;
    do_reset();
    wr(3'd4, 16'hA580); wr(3'd0, 16'h5AFF);
    edges(31); check("R7 irq before wrap", irq, 0);
    edges(1);
    rd(3'd4, d); check("R7 interval flag", d, 8'h88);
    check("R7 irq on", irq, 1);
    check("R7 no reset request", rst_req, 0);
    edges(40); check("R7 irq held", irq, 1);
    check("R7 still no reset", rst_req, 0);
    wr(3'd4, 16'hA580); check("R8 irq cleared", irq, 0);
  endtask

  task automatic t_clear_vs_wrap();
    logic [7:0] d;
    do_reset();
    wr(3'd4, 16'hA5C0); wr(3'd0, 16'h5AFF);
    edges(31);
    wr(3'd4, 16'hA5C0);
    rd(3'd4, d); check("R9 flag survives clear on wrap edge", d, 8'hD0);
    check("R9 reset pulse starts", rst_req, 1);
  endtask

  task automatic t_load_vs_wrap();
    logic [7:0] d;
    do_reset();
    wr(3'd4, 16'hA5C0); wr(3'd0, 16'h5AFF);
    edges(31);
    wr(3'd0, 16'h5A20);
    rd(3'd0, d); check("R10 reload wins", d, 8'h20);
    rd(3'd4, d); check("R10 no flag", d, 8'hC0);
    check("R10 no reset", rst_req, 0);
    edges(31); rd(3'd0, d); check("R10 full period after reload", d, 8'h20);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog timeout actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_keys();
    t_rate();
    t_watchdog();
    t_interval();
    t_clear_vs_wrap();
    t_load_vs_wrap();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule